// File: doc/BRIEF.md
# BCD Up/Down Decade Counter

A single decimal digit that counts up or down through 0..9 on the rising clock edge. An active-low count enable lets the clock advance the digit. A direction select picks the direction: high counts up, low counts down. An active-low load input presets the digit asynchronously from four data bits. While the load is held low, the data bits appear directly on the count output and override all counting.

Two flags support cascading. The terminal flag is decoded from the count and the direction only. It is high at 9 when counting up and at 0 when counting down. The count enable has no effect on it. The active-low ripple pulse goes low only during the low phase of the clock, and only when the digit is enabled, not loading, and at its terminal value. It rises again with the clock. Codes 10..15 can only enter through the load. The next enabled edge returns them to a legal digit.

Top module: `bcd_updown_digit`

## Requirements
- R1: While `load_n` is low, `count` equals `pdata` and follows changes of `pdata` without a clock edge. The value held when `load_n` rises is the one present at the last rising clock edge or falling `load_n` edge.
- R2: With `load_n` high and `cnt_en_n` high, a rising clock edge leaves `count` unchanged.
- R3: With `load_n` high, `cnt_en_n` low and `up_dn` high (up), each rising edge adds one to a legal count, and 9 becomes 0.
- R4: With `load_n` high, `cnt_en_n` low and `up_dn` low (down), each rising edge subtracts one from a legal count, and 0 becomes 9.
- R5: `term` is high exactly when `count` is 9 with `up_dn` high, or `count` is 0 with `up_dn` low. It follows `up_dn` and `count` without a clock edge, and `cnt_en_n` has no effect on it.
- R6: `ripple_n` is low exactly when `clk` is low, `cnt_en_n` is low, `load_n` is high and `term` is high. It is high while `clk` is high.
- R7: A high `cnt_en_n` or a low `load_n` keeps `ripple_n` high, including during the low phase of the clock.
- R8: A count of 10..15 never raises `term`. The next enabled rising edge moves it to 0 when counting up, or to 9 when counting down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; state advances on the rising edge |
| cnt_en_n | input | 1 | Count enable, active low |
| up_dn | input | 1 | Direction: 1 counts up, 0 counts down |
| load_n | input | 1 | Asynchronous preset, active low |
| pdata | input | 4 | Preset value |
| count | output | 4 | Current digit |
| term | output | 1 | Terminal flag for the selected direction |
| ripple_n | output | 1 | Active-low carry/borrow pulse in the clock's low phase |

## Verification
On every clock edge, the assertions check the up and down wrap points, the hold under a high enable, the one-step increment, the recovery from illegal codes, the absence of a terminal flag on illegal codes, and a high ripple output during the clock's high phase. Only the bench's scenarios show the following: the count following `pdata` between edges while loading, `term` reacting at once to a change of `up_dn`, and the exact shape of the ripple pulse in the low phase against enable and load. The bench samples these at chosen points inside the cycle.

// File: rtl/bcd_updown_digit.sv
module bcd_updown_digit (
  input  logic       clk,
  input  logic       cnt_en_n,
  input  logic       up_dn,
  input  logic       load_n,
  input  logic [3:0] pdata,
  output logic [3:0] count,
  output logic       term,
  output logic       ripple_n
);
  localparam logic [3:0] TOP = 4'd9;
  localparam logic [3:0] BOT = 4'd0;

  logic [3:0] st;
  logic [3:0] nxt;
  logic       legal;

  always_comb begin
    if (up_dn) nxt = (st >= TOP) ? BOT : st + 4'd1;
    else       nxt = (st == BOT || st > TOP) ? TOP : st - 4'd1;
  end

  always_ff @(posedge clk or negedge load_n)
    if (!load_n)        st <= pdata;
    else if (!cnt_en_n) st <= nxt;

  assign count    = load_n ? st : pdata;
  assign legal    = count <= TOP;
  assign term     = legal && (up_dn ? count == TOP : count == BOT);
  assign ripple_n = !(term && !cnt_en_n && load_n && !clk);
endmodule

// File: rtl/bcd_digit_chk.sv
module bcd_digit_chk (
  input logic       clk,
  input logic       cnt_en_n,
  input logic       up_dn,
  input logic       load_n,
  input logic [3:0] count,
  input logic       term,
  input logic       ripple_n
);
  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!load_n)
    cnt_en_n |=> $stable(count)); // R2
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && up_dn && count < 4'd9) |=> count == $past(count) + 4'd1); // R3
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && up_dn && count == 4'd9) |=> count == 4'd0); // R3
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && !up_dn && count == 4'd0) |=> count == 4'd9); // R4
  AST_NO_TERM_ILLEGAL: assert property (@(posedge clk) disable iff (!load_n)
    (count > 4'd9) |-> !term); // R8
  AST_ILLEGAL_RECOVER: assert property (@(posedge clk) disable iff (!load_n)
    (!cnt_en_n && count > 4'd9) |=> count == ($past(up_dn) ? 4'd0 : 4'd9)); // R8
  AST_RIPPLE_HIGH_PHASE: assert property (@(negedge clk) disable iff (!load_n)
    ripple_n); // R6
endmodule

bind bcd_updown_digit bcd_digit_chk u_chk (
  .clk(clk), .cnt_en_n(cnt_en_n), .up_dn(up_dn), .load_n(load_n),
  .count(count), .term(term), .ripple_n(ripple_n)
);

// File: tb/sim_bcd_updown_digit.sv
`timescale 1ns/1ps
module sim_bcd_updown_digit;
  logic clk = 1'b0;
  logic cnt_en_n = 1'b1, up_dn = 1'b1, load_n = 1'b0;
  logic [3:0] pdata = 4'd0;
  logic [3:0] count;
  logic term, ripple_n;
  int checks = 0, fails = 0;
  logic [3:0] exp_st = 4'd0;

  always #2.5 clk = ~clk;

  bcd_updown_digit u0 (.clk(clk), .cnt_en_n(cnt_en_n), .up_dn(up_dn), .load_n(load_n),
                       .pdata(pdata), .count(count), .term(term), .ripple_n(ripple_n));

  function automatic logic [3:0] f_next(logic [3:0] s, logic up);
    if (up) return (s >= 4'd9) ? 4'd0 : s + 4'd1;
    return (s == 4'd0 || s > 4'd9) ? 4'd9 : s - 4'd1;
  endfunction

  function automatic logic f_term(logic [3:0] s, logic up);
    return (s <= 4'd9) && (up ? s == 4'd9 : s == 4'd0);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(logic en_n, logic up, logic ld_n, logic [3:0] d);
    logic [3:0] shown;
    string tag;
    cnt_en_n = en_n; up_dn = up; load_n = ld_n; pdata = d;
    #0.5;
    if (!ld_n) exp_st = d;
    shown = exp_st;
    if (!ld_n) tag = "R1";
    else tag = "R2/R3/R4/R8";
    chk(tag, count, shown);
    chk("R5", term, f_term(shown, up));
    if (shown > 4'd9) chk("R8", term, 0);
    @(negedge clk); #0.5;
    if (en_n || !ld_n) chk("R7", ripple_n, 1);
    else chk("R6", ripple_n, !f_term(shown, up));
    @(posedge clk);
    if (ld_n && !en_n) exp_st = f_next(exp_st, up);
    #1;
    if (ld_n) begin
      if (en_n) tag = "R2";
      else if (shown > 4'd9) tag = "R8";
      else if (up) tag = "R3";
      else tag = "R4";
      chk(tag, count, exp_st);
    end
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk); #1;
    chk("R1", count, 0);
    cyc(1, 1, 0, 4'd0);
    // R1: count follows pdata between edges while loading
    pdata = 4'd3; #0.5; chk("R1", count, 3);
    pdata = 4'd6; #0.5; chk("R1", count, 6);
    @(posedge clk); #1;
    exp_st = 4'd6;
    // R2 hold
    cyc(1, 1, 1, 4'd2);
    cyc(1, 0, 1, 4'd2);
    // R3 up through wrap
    for (int i = 0; i < 12; i++) cyc(0, 1, 1, 4'd0);
    // R4 down through wrap
    for (int i = 0; i < 12; i++) cyc(0, 0, 1, 4'd0);
    // R5: term follows direction, unaffected by enable
    cyc(1, 1, 0, 4'd9);
    up_dn = 1'b0; cnt_en_n = 1'b1; load_n = 1'b1; #0.5; chk("R5", term, 0);
    up_dn = 1'b1; #0.5; chk("R5", term, 1);
    cnt_en_n = 1'b0; #0.5; chk("R5", term, 1);
    @(posedge clk); #1; exp_st = 4'd0; chk("R3", count, 0);
    up_dn = 1'b0; #0.5; chk("R5", term, 1);
    @(posedge clk); #1; exp_st = 4'd9; chk("R4", count, 9);
    // R8: every illegal code in both directions
    for (int c = 10; c < 16; c++) begin
      cyc(1, 1, 0, 4'(c));
      cyc(0, 1, 1, 4'd0);
      cyc(1, 0, 0, 4'(c));
      cyc(0, 0, 1, 4'd0);
    end
    // R7 with terminal held high
    cyc(1, 1, 0, 4'd9);
    cyc(1, 1, 1, 4'd0);
    cyc(0, 1, 0, 4'd9);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic ld;
      ld = ($urandom % 20) != 0;
      cyc(($urandom % 4) == 0, ($urandom % 3) != 0, ld, 4'($urandom % 16));
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule